// File: doc/BRIEF.md
# Port Interrupt Status and Enable Controller

This block collects twelve single-cycle event pulses from a storage link port and holds each one in a sticky status bit. Software sees a single 32-bit status word with two views of the same events: the unmasked copy in the upper half and the enable-filtered copy in the lower bits. One interrupt line is raised whenever any filtered bit is set.

The enable mask has no plain write. Software turns sources on through an enable-set address and off through an enable-clear address; writing ones selects the bits to change. Both enable addresses also load a two-bit steering field from the top of the written word. Pending events are acknowledged by writing ones to the status address, so writing back a value just read acknowledges everything it showed. A mode input chooses how the completion event is acknowledged.

Top module: `port_irq_ctl`

## Requirements
- R1: An event pulse on `evt_i[k]` sets raw status bit `stat_o[16+k]` on the next clock edge. The bit stays set until it is acknowledged. Event numbering: completion 0, error 1, port-ready change 2, power change 3, PHY-ready change 4, COMWAKE 5, unknown FIS 6, device exchanged 7, decode-error threshold 8, CRC threshold 9, handshake threshold 10, SDB notify 11.
- R2: Bits 10:0 of `stat_o` equal raw bits 26:16 ANDed with enable bits 10:0. Event 11 shows only in the raw view, at bit 27. Bits 15:11 and 31:28 read zero.
- R3: `irq_o` is high exactly when any of `stat_o[10:0]` is set.
- R4: A write to byte offset 0x10 ORs `wr_data_i[11:0]` into the enable mask. A write to offset 0x14 clears every enable bit written as one, so the value 0xFFFF masks all sources.
- R5: A write to offset 0x10 or 0x14 loads `steer_o` from `wr_data_i[31:30]`. Other writes leave it unchanged.
- R6: A write to offset 0x08 clears status bit k when `wr_data_i[k]` or `wr_data_i[16+k]` is one. Writing back the read value therefore acknowledges all pending events.
- R7: If an event pulse and a clearing write for the same bit occur in the same cycle, the bit stays set.
- R8: With `woc_mode_i` low, any write to offset 0x08 clears the completion bit, whatever the data. With `woc_mode_i` high, the completion bit clears only when it is written as one.
- R9: After reset, the raw status, enable mask and steering field are all zero, and `irq_o` is low.
- R10: Writes to any other offset change neither the status, the enables nor the steering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | Single-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| woc_mode_i | input | 1 | 1: completion must be written as one to clear |
| stat_o | output | 32 | Status word: raw view in bits 27:16, masked view in bits 10:0 |
| irq_o | output | 1 | Interrupt request |
| steer_o | output | 2 | Interrupt steering field |

## Verification
The bench targets an event landing in the same cycle as its own acknowledge. A design that lets the clear win would silently drop that event. It checks that SDB notify stays out of the masked view and the interrupt even when enabled; a design with a 12-bit masked field would raise a spurious interrupt. Clears are written through only the upper half, so a design decoding only the low half would leave bit 27 set. Completion acknowledge is run in both modes, and a design ignoring the mode either keeps a stale completion or loses one. Steering loads are checked from the enable-clear address, and a write to an unrelated offset with all ones is checked to leave everything unchanged.

// File: rtl/port_irq_ctl_pkg.sv
package port_irq_ctl_pkg;
    localparam int NUM_EVT   = 12;
    localparam int VIEW_W    = 11;
    localparam int RAW_SHIFT = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int STEER_W   = 2;
    localparam int STEER_LSB = DATA_W - STEER_W;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h14;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_STAT  = 2'd1,
        TGT_ENSET = 2'd2,
        TGT_ENCLR = 2'd3
    } wr_target_e;
endpackage

// File: rtl/port_irq_ctl_decode.sv
module port_irq_ctl_decode
    import port_irq_ctl_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output wr_target_e        target_o
);
    always_comb begin
        target_o = TGT_NONE;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                OFS_STAT:  target_o = TGT_STAT;
                OFS_ENSET: target_o = TGT_ENSET;
                OFS_ENCLR: target_o = TGT_ENCLR;
                default:   target_o = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/port_irq_ctl_enable.sv
module port_irq_ctl_enable
    import port_irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wr_target_e         target_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [NUM_EVT-1:0] en_o,
    output logic [STEER_W-1:0] steer_o
);
    logic [NUM_EVT-1:0] en_n;
    logic [STEER_W-1:0] steer_n;

    always_comb begin
        en_n    = en_o;
        steer_n = steer_o;
        unique case (target_i)
            TGT_ENSET: begin
                en_n    = en_o | wr_data_i[NUM_EVT-1:0];
                steer_n = wr_data_i[STEER_LSB +: STEER_W];
            end
            TGT_ENCLR: begin
                en_n    = en_o & ~wr_data_i[NUM_EVT-1:0];
                steer_n = wr_data_i[STEER_LSB +: STEER_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            steer_o <= '0;
        end else begin
            en_o    <= en_n;
            steer_o <= steer_n;
        end
    end
endmodule

// File: rtl/port_irq_ctl_status.sv
module port_irq_ctl_status
    import port_irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  wr_target_e         target_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               woc_mode_i,
    output logic [NUM_EVT-1:0] raw_o
);
    logic [NUM_EVT-1:0] clr;
    logic [NUM_EVT-1:0] raw_n;

    always_comb begin
        clr = '0;
        if (target_i == TGT_STAT) begin
            clr = wr_data_i[NUM_EVT-1:0] | wr_data_i[RAW_SHIFT +: NUM_EVT];
            if (!woc_mode_i)
                clr[0] = 1'b1;
        end
        raw_n = (raw_o & ~clr) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_o <= '0;
        else
            raw_o <= raw_n;
    end
endmodule

// File: rtl/port_irq_ctl.sv
module port_irq_ctl
    import port_irq_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               woc_mode_i,
    output logic [DATA_W-1:0]  stat_o,
    output logic               irq_o,
    output logic [STEER_W-1:0] steer_o
);
    wr_target_e         target;
    logic [NUM_EVT-1:0] en;
    logic [NUM_EVT-1:0] raw;
    logic [VIEW_W-1:0]  masked;

    port_irq_ctl_decode u_decode (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .target_o  (target)
    );

    port_irq_ctl_enable u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .target_i  (target),
        .wr_data_i (wr_data_i),
        .en_o      (en),
        .steer_o   (steer_o)
    );

    port_irq_ctl_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .target_i   (target),
        .wr_data_i  (wr_data_i),
        .woc_mode_i (woc_mode_i),
        .raw_o      (raw)
    );

    always_comb begin
        masked = raw[VIEW_W-1:0] & en[VIEW_W-1:0];
        stat_o = '0;
        stat_o[RAW_SHIFT +: NUM_EVT] = raw;
        stat_o[VIEW_W-1:0]           = masked;
        irq_o  = |masked;
    end
endmodule

// File: rtl/port_irq_ctl_chk.sv
module port_irq_ctl_chk
    import port_irq_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic               woc_mode_i,
    input logic [DATA_W-1:0]  stat_o,
    input logic               irq_o,
    input logic [STEER_W-1:0] steer_o
);
    logic is_en_wr;
    logic is_known;
    assign is_en_wr = wr_en_i && (wr_addr_i == OFS_ENSET || wr_addr_i == OFS_ENCLR);
    assign is_known = is_en_wr || wr_addr_i == OFS_STAT;

    // R1 and R7: a pulsed event is always visible in the raw view next cycle
    assert_event_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o[RAW_SHIFT +: NUM_EVT] & $past(evt_i)) == $past(evt_i)));

    assert_masked_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o[VIEW_W-1:0] & ~stat_o[RAW_SHIFT +: VIEW_W]) == '0));

    assert_irq_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (stat_o[VIEW_W-1:0] != '0));

    assert_steer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !is_en_wr |=> $stable(steer_o));

    assert_ack_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == OFS_STAT && (&wr_data_i) && evt_i == '0)
        |=> (stat_o[RAW_SHIFT +: NUM_EVT] == '0));

    assert_implicit_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == OFS_STAT && !woc_mode_i && !evt_i[0])
        |=> !stat_o[RAW_SHIFT]);

    assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !is_known && evt_i == '0) |=> ($stable(stat_o) && $stable(steer_o)));
endmodule

bind port_irq_ctl port_irq_ctl_chk u_chk (.*);

// File: tb/port_irq_ctl_test.sv
module port_irq_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        woc_mode_i = 1'b1;
    logic [31:0] stat_o;
    logic        irq_o;
    logic [1:0]  steer_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .woc_mode_i(woc_mode_i),
        .stat_o(stat_o), .irq_o(irq_o), .steer_o(steer_o)
    );

    // kind: 0 none, 1 status 0x08, 2 enable-set 0x10, 3 enable-clear 0x14, 4 other 0x0C
    // fields: evt(12) kind(3) data(32) woc(1) exp_stat(32) exp_irq(1) exp_steer(2)
    localparam logic [82:0] VEC [NV] = '{
        {12'h001, 3'd0, 32'h00000000, 1'b1, 32'h00010000, 1'b0, 2'd0}, // R1
        {12'h000, 3'd2, 32'h000000C3, 1'b1, 32'h00010001, 1'b1, 2'd0}, // R4 default set
        {12'h080, 3'd0, 32'h00000000, 1'b1, 32'h00810081, 1'b1, 2'd0}, // R1 R2
        {12'h000, 3'd1, 32'h00810081, 1'b1, 32'h00000000, 1'b0, 2'd0}, // R6 write-back
        {12'h800, 3'd0, 32'h00000000, 1'b1, 32'h08000000, 1'b0, 2'd0}, // R1 bit 11
        {12'h000, 3'd2, 32'h00000800, 1'b1, 32'h08000000, 1'b0, 2'd0}, // R2 bit 11 raw only
        {12'h004, 3'd0, 32'h00000000, 1'b1, 32'h08040000, 1'b0, 2'd0}, // R2 not enabled
        {12'h000, 3'd3, 32'h0000FFFF, 1'b1, 32'h08040000, 1'b0, 2'd0}, // R4 mask all
        {12'h000, 3'd2, 32'h80000004, 1'b1, 32'h08040004, 1'b1, 2'd2}, // R4 R5
        {12'h000, 3'd1, 32'h08000000, 1'b1, 32'h00040004, 1'b1, 2'd2}, // R6 upper half
        {12'h004, 3'd1, 32'h00000004, 1'b1, 32'h00040004, 1'b1, 2'd2}, // R7
        {12'h000, 3'd1, 32'h00000004, 1'b1, 32'h00000000, 1'b0, 2'd2}, // R6 lower half
        {12'h000, 3'd3, 32'h40000000, 1'b1, 32'h00000000, 1'b0, 2'd1}, // R5 via clear
        {12'h001, 3'd0, 32'h00000000, 1'b0, 32'h00010000, 1'b0, 2'd1}, // R1
        {12'h000, 3'd1, 32'h00000000, 1'b0, 32'h00000000, 1'b0, 2'd1}, // R8 implicit
        {12'h001, 3'd0, 32'h00000000, 1'b1, 32'h00010000, 1'b0, 2'd1}, // R1
        {12'h000, 3'd1, 32'h00000000, 1'b1, 32'h00010000, 1'b0, 2'd1}, // R8 explicit
        {12'h000, 3'd4, 32'hFFFFFFFF, 1'b1, 32'h00010000, 1'b0, 2'd1}, // R10
        {12'h000, 3'd1, 32'h00010000, 1'b1, 32'h00000000, 1'b0, 2'd1}, // R6
        {12'hFFF, 3'd0, 32'h00000000, 1'b1, 32'h0FFF0004, 1'b1, 2'd1}, // R1 all
        {12'h000, 3'd2, 32'h00000FFF, 1'b1, 32'h0FFF07FF, 1'b1, 2'd0}  // R2 R3 R5
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] kind_addr(input logic [2:0] k);
        case (k)
            3'd1: return 8'h08;
            3'd2: return 8'h10;
            3'd3: return 8'h14;
            default: return 8'h0C;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check32("R9 stat", stat_o, 32'h0);
        check32("R9 irq", {31'b0, irq_o}, 32'h0);
        check32("R9 steer", {30'b0, steer_o}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [82:0] v;
            v = VEC[i];
            evt_i      = v[82:71];
            wr_en_i    = (v[70:68] != 3'd0);
            wr_addr_i  = kind_addr(v[70:68]);
            wr_data_i  = v[67:36];
            woc_mode_i = v[35];
            @(negedge clk);
            evt_i   = '0;
            wr_en_i = 1'b0;
            check32($sformatf("R1-table%0d stat", i), stat_o, v[34:3]);
            check32($sformatf("R3 table%0d irq", i), {31'b0, irq_o}, {31'b0, v[2]});
            check32($sformatf("R5 table%0d steer", i), {30'b0, steer_o}, {30'b0, v[1:0]});
        end
        // R9: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check32("R9 re-reset stat", stat_o, 32'h0);
        check32("R9 re-reset steer", {30'b0, steer_o}, 32'h0);
        rst_n = 1'b1;
        // R4 after reset: enables are zero, an event is not masked through
        evt_i = 12'h002;
        @(negedge clk);
        evt_i = '0;
        check32("R4 enables cleared by reset", stat_o, 32'h00020000);
        check32("R3 no irq when disabled", {31'b0, irq_o}, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule